// File: doc/BRIEF.md
# Card and Password Authentication Unit

The unit decides whether an inserted card may proceed. It keeps an internal table of card records. Each record pairs a card number with the password that belongs to it. The table is loaded through a simple write port before use.

When a card strobe arrives, the unit scans the table from the lowest address upward, reading one record per clock. If no record carries that card number, the unit reports that the card is kept. If a record matches, the unit latches that record's password and raises a password request. It then accepts password strobes. A correct password grants access. After three wrong passwords the card is kept.

Each result stays on its output until the next accepted card strobe. Card strobes that arrive while a scan or a password exchange is in progress are ignored. Password strobes are ignored whenever no password has been requested.

Top module: `card_auth`

## Requirements
- R1: A write with `tbl_we` high stores `tbl_wdata` at `tbl_addr`. Bits 15:8 of a record are the card number and bits 7:0 are its password. A record rewritten while the unit is idle is used by the next scan.
- R2: The scan starts at address 0, reads one address per clock and stops at the first match. If a card strobe is sampled at edge k and the lowest matching address is i, then `pw_req` rises after edge k+1+i and the password of record i is the one checked.
- R3: If no record matches, `card_kept` rises after edge k+256 and `pw_req` never rises for that card.
- R4: A password equal to the stored one, given with `pw_stb` while `pw_req` is high, sets `auth_ok` and clears `pw_req` on the next edge. This holds on the first, second or third try.
- R5: A wrong password on the first or second try keeps `pw_req` high and sets neither result output.
- R6: A wrong password on the third try sets `card_kept` and clears `pw_req` on the next edge.
- R7: `auth_ok` and `card_kept` are never high together. Each holds until the next accepted card strobe, which clears both on the following edge.
- R8: `card_stb` is ignored while a scan runs or a password is requested. `pw_stb` is ignored while `pw_req` is low.
- R9: After reset, `pw_req`, `auth_ok` and `card_kept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write address |
| tbl_wdata | input | 16 | Record to write: {card number, password} |
| card_stb | input | 1 | One-cycle card insertion strobe |
| card_id | input | 8 | Card number, sampled with `card_stb` |
| pw_stb | input | 1 | One-cycle password strobe |
| pw_val | input | 8 | Password, sampled with `pw_stb` |
| pw_req | output | 1 | A password is requested |
| auth_ok | output | 1 | Card and password accepted |
| card_kept | output | 1 | Card is retained |

## Verification
Every one of the 256 card numbers is inserted against a table filled by an odd-multiplier formula. One record is made to duplicate an earlier card number, so exactly one number is absent. The measured latency then separates a first-match scan from a last-match scan, and also separates the miss path from any hit. The number of wrong passwords before the right one is cycled from zero to three across the cards. This exercises authentication on each try and retention on the third failure. Some cards receive stray card and password strobes while a scan or a password exchange is in progress, and some receive them while a result is being held. A record rewritten after the preload must then be the one found.

// File: rtl/card_auth.sv
module card_auth #(
  parameter int ENTRIES = 256,
  parameter int KEY_W   = 8,
  parameter int PW_W    = 8,
  parameter int TRIES   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tbl_we,
  input  logic [$clog2(ENTRIES)-1:0] tbl_addr,
  input  logic [KEY_W+PW_W-1:0]      tbl_wdata,
  input  logic                       card_stb,
  input  logic [KEY_W-1:0]           card_id,
  input  logic                       pw_stb,
  input  logic [PW_W-1:0]            pw_val,
  output logic                       pw_req,
  output logic                       auth_ok,
  output logic                       card_kept
);
  localparam int AW = $clog2(ENTRIES);
  localparam int WW = KEY_W + PW_W;
  localparam int TW = $clog2(TRIES + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(ENTRIES - 1);
  localparam logic [TW-1:0] LAST_TRY  = TW'(TRIES - 1);

  typedef enum logic [1:0] {IDLE, SCAN, ASK} state_t;

  state_t          state;
  logic [WW-1:0]   table_q [ENTRIES];
  logic [AW-1:0]   scan_addr;
  logic [KEY_W-1:0] card_q;
  logic [PW_W-1:0] pw_q;
  logic [TW-1:0]   tries;

  always_ff @(posedge clk)
    if (tbl_we) table_q[tbl_addr] <= tbl_wdata;

  logic [WW-1:0]    entry;
  logic [KEY_W-1:0] entry_key;
  logic [PW_W-1:0]  entry_pw;
  logic hit, scan_end, pw_good, last_try;

  assign entry     = table_q[scan_addr];
  assign entry_key = entry[WW-1:PW_W];
  assign entry_pw  = entry[PW_W-1:0];
  assign hit       = entry_key == card_q;
  assign scan_end  = scan_addr == LAST_ADDR;
  assign pw_good   = pw_val == pw_q;
  assign last_try  = tries == LAST_TRY;
  assign pw_req    = state == ASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      scan_addr <= '0;
      card_q    <= '0;
      pw_q      <= '0;
      tries     <= '0;
      auth_ok   <= 1'b0;
      card_kept <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (card_stb) begin
          card_q    <= card_id;
          scan_addr <= '0;
          auth_ok   <= 1'b0;
          card_kept <= 1'b0;
          state     <= SCAN;
        end
        SCAN: begin
          if (hit) begin
            pw_q  <= entry_pw;
            tries <= '0;
            state <= ASK;
          end else if (scan_end) begin
            card_kept <= 1'b1;
            state     <= IDLE;
          end else begin
            scan_addr <= scan_addr + 1'b1;
          end
        end
        ASK: if (pw_stb) begin
          if (pw_good) begin
            auth_ok <= 1'b1;
            state   <= IDLE;
          end else if (last_try) begin
            card_kept <= 1'b1;
            state     <= IDLE;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_first_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SCAN && hit) |=> pw_req && pw_q == $past(entry_pw));
  assert_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SCAN && scan_end && !hit) |=> card_kept && !pw_req);
  assert_good_pw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_req && pw_stb && pw_good) |=> auth_ok && !pw_req);
  assert_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_req && pw_stb && !pw_good && !last_try) |=> pw_req && !auth_ok && !card_kept && $stable(pw_q));
  assert_try_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= LAST_TRY);
  assert_third_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_req && pw_stb && !pw_good && last_try) |=> card_kept && !pw_req);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(auth_ok && card_kept) && !(pw_req && (auth_ok || card_kept)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((auth_ok || card_kept) && !card_stb) |=> $stable(auth_ok) && $stable(card_kept));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE && card_stb) |=> $stable(card_q));
endmodule

// File: tb/tb_card_auth.sv
module tb_card_auth;
  localparam int N = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tbl_we, card_stb, pw_stb;
  logic [7:0] tbl_addr, card_id, pw_val;
  logic [15:0] tbl_wdata;
  logic pw_req, auth_ok, card_kept;

  card_auth dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .card_stb(card_stb), .card_id(card_id),
    .pw_stb(pw_stb), .pw_val(pw_val), .pw_req(pw_req),
    .auth_ok(auth_ok), .card_kept(card_kept)
  );

  logic [15:0] model [N];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] cardv(int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  function automatic logic [7:0] pwv(int i);
    return 8'((i * 13 + 5) % 256);
  endfunction

  function automatic int find(logic [7:0] cv);
    for (int i = 0; i < N; i++)
      if (model[i][15:8] == cv) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_rec(int a, logic [15:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'(a); tbl_wdata = d; model[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic start_card(logic [7:0] cv, bit noisy, output int lat);
    @(negedge clk);
    card_id = cv; card_stb = 1'b1;
    @(negedge clk);
    card_stb = 1'b0;
    chk(!auth_ok && !card_kept, "R7 results cleared by card strobe", {auth_ok, card_kept}, 0);
    lat = 0;
    while (!pw_req && !card_kept && lat < 300) begin
      if (noisy && lat == 2) begin
        card_stb = 1'b1; card_id = ~cv; pw_stb = 1'b1; pw_val = 8'h00;
      end
      @(negedge clk);
      card_stb = 1'b0; pw_stb = 1'b0;
      lat++;
    end
  endtask

  task automatic send_pw(logic [7:0] v);
    pw_val = v; pw_stb = 1'b1;
    @(negedge clk);
    pw_stb = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, idx, w;
    logic [7:0] good;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    card_stb = 1'b0; card_id = '0; pw_stb = 1'b0; pw_val = '0;
    repeat (3) @(negedge clk);
    chk(!pw_req && !auth_ok && !card_kept, "R9 reset outputs low", {pw_req, auth_ok, card_kept}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) write_rec(i, {cardv(i), pwv(i)});
    write_rec(200, {cardv(50), pwv(200)});

    for (int v = 0; v < 256; v++) begin
      bit noisy;
      bit exp_auth;
      noisy = (v % 16) == 5;
      idx = find(8'(v));
      start_card(8'(v), noisy, lat);
      if (idx < 0) begin
        chk(card_kept && !pw_req && lat == 256, "R3 unknown card kept after full scan", lat, 256);
        exp_auth = 1'b0;
      end else begin
        chk(pw_req && lat == idx + 1, noisy ? "R8 strobes during scan ignored" : "R2 first match latency", lat, idx + 1);
        good = model[idx][7:0];
        w = v % 4;
        for (int t = 0; t < w; t++) begin
          send_pw(good ^ 8'(t + 1));
          if (t < 2)
            chk(pw_req && !auth_ok && !card_kept, "R5 wrong password asks again", {pw_req, auth_ok, card_kept}, 4);
          else
            chk(card_kept && !pw_req && !auth_ok, "R6 third wrong password keeps card", {pw_req, auth_ok, card_kept}, 1);
        end
        if (w < 3) begin
          send_pw(good);
          chk(auth_ok && !pw_req && !card_kept, "R4 correct password authenticates", {pw_req, auth_ok, card_kept}, 2);
        end
        exp_auth = w < 3;
      end
      pw_val = exp_auth ? 8'h00 : good; pw_stb = 1'b1;
      @(negedge clk);
      pw_stb = 1'b0;
      repeat (2) @(negedge clk);
      chk(auth_ok == exp_auth && card_kept == !exp_auth && !pw_req, "R7 R8 result held, idle password ignored",
          {pw_req, auth_ok, card_kept}, {1'b0, exp_auth, !exp_auth});
    end

    start_card(cardv(10), 1'b0, lat);
    chk(pw_req && lat == 11, "R2 match at index 10", lat, 11);
    card_id = cardv(20); card_stb = 1'b1;
    @(negedge clk);
    card_stb = 1'b0;
    chk(pw_req && !auth_ok && !card_kept, "R8 card strobe ignored while asking", {pw_req, auth_ok, card_kept}, 4);
    send_pw(pwv(10));
    chk(auth_ok && !pw_req, "R8 stored password unchanged by ignored strobe", auth_ok, 1);

    write_rec(3, {cardv(200), 8'h5A});
    start_card(cardv(200), 1'b0, lat);
    chk(pw_req && lat == 4, "R1 rewritten record found", lat, 4);
    send_pw(8'h5A);
    chk(auth_ok && !card_kept, "R1 rewritten password accepted", auth_ok, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule